// File: doc/BRIEF.md
# Parity-Checked Asynchronous Serial Link

This block is the character link of a protected serial memory. Bytes arrive on a single input line as asynchronous characters: a low start bit, eight data bits least significant first, an optional even parity bit, and a high stop bit. The link rebuilds each byte and hands it to the command engine with a one-cycle strobe. Bytes the engine returns are framed the same way and sent on a separate output line, which is driven only while a response or a busy level is being shown. The bit period is a whole number of system clocks; the default of 512 gives 9600 baud from a 4.9152 MHz clock.

A level on the parity-select input turns the parity bit on or off for both directions at once. A received parity bit that does not match kills the link. No byte is delivered, the transmitter refuses work, and the open-drain error output pulls low. A sticky flag goes to the status register. Only a low level on chip select clears this state. Chip select low also stops any transfer that is under way and releases the output line.

Top module: `serlink_front`

## Requirements
- R1: A character is a start bit of 0, then 8 data bits with bit 0 first, then a stop bit of 1. Each received byte appears on `rx_data` with `rx_valid` high for exactly one cycle. Each byte accepted on `tx_data` is sent in the same format on `tx_out`.
- R2: With `par_en` high, an even parity bit follows bit 7 in both directions. The parity bit is the XOR of the 8 data bits. With `par_en` low, no parity bit is sent and none is expected.
- R3: One bit lasts `BIT_CLKS` clock cycles. The receiver samples each bit in the middle of its period.
- R4: A 1 on `rx_in` while the receiver is idle is ignored, however long it lasts. A 0 while idle begins a character. If the line is back at 1 at the middle of the start bit, the character is dropped and no byte is delivered.
- R5: A parity mismatch delivers no byte. It sets `par_err_flag` and `err_pull`, and drops `tx_ready`. All three stay in that state, and later characters are ignored, for as long as `chip_sel` stays high.
- R6: While `chip_sel` is low, `tx_oe` and `tx_ready` are 0 and any transfer is abandoned. One cycle after `chip_sel` goes low, `par_err_flag` and `err_pull` are 0.
- R7: `tx_oe` is 0 except during a response or a busy indication. After the stop bit of a byte sent with `tx_last` = 1, `tx_oe` returns to 0.
- R8: After the stop bit of a byte sent with `tx_last` = 0, the line stays driven at 1 until the next byte starts.
- R9: When the transmitter is idle and not holding the line between response bytes, `busy_on` = 1 drives `busy_lvl` onto `tx_out` with `tx_oe` = 1.
- R10: `tx_ready` is high only when the link is live and the transmitter is idle. A byte taken on `tx_valid` and `tx_ready` drops `tx_ready` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Link enable; low resets the link |
| par_en | input | 1 | 1 = even parity bit in each character |
| rx_in | input | 1 | Serial data in, idle high |
| tx_out | output | 1 | Serial data out level |
| tx_oe | output | 1 | 1 = `tx_out` is driven, 0 = high impedance |
| err_pull | output | 1 | 1 = open-drain error pin pulled low |
| par_err_flag | output | 1 | Sticky parity-error flag for the status register |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_last | input | 1 | Offered byte ends the response |
| tx_ready | output | 1 | Transmitter accepts a byte |
| busy_on | input | 1 | Show the busy level while idle |
| busy_lvl | input | 1 | Busy level to drive |

## Verification
The hardest state to reach is the dead link. It exists only after a character whose parity bit is wrong, which a well-behaved sender never makes. The stimulus therefore builds a character by hand with a deliberately inverted parity bit. It then sends a correct character and offers a transmit byte to show that nothing gets through. A chip select pulse follows, and the link must work again. A second rare case is a start bit that is too short: a low pulse of a few clocks, well under half a bit, has to vanish without leaving the receiver out of step for the next real character.

// File: rtl/serlink_pkg.sv
package serlink_pkg;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_DEAD
  } rx_state_t;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_state_t;

  function automatic logic even_bit(input logic [7:0] d);
    return ^d;
  endfunction

endpackage

// File: rtl/serlink_rx.sv
module serlink_rx
  import serlink_pkg::*;
#(
  parameter int BIT_CLKS = 512,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              par_en,
  input  logic              rx_in,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err
);
  localparam int CNT_W = $clog2(BIT_CLKS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(BIT_CLKS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(BIT_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_W - 1);

  rx_state_t         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              vld_q, vld_d;
  logic              err_q, err_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    idx_d = idx_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    err_d = err_q;
    case (st_q)
      RX_IDLE: begin
        cnt_d = '0;
        if (!rx_in) st_d = RX_START;
      end
      RX_START: if (cnt_q == HALF_M1) begin
        cnt_d = '0;
        idx_d = '0;
        st_d  = rx_in ? RX_IDLE : RX_DATA;
      end
      RX_DATA: if (cnt_q == FULL_M1) begin
        cnt_d = '0;
        sh_d  = {rx_in, sh_q[DATA_W-1:1]};
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_TOP) st_d = par_en ? RX_PAR : RX_STOP;
      end
      RX_PAR: if (cnt_q == FULL_M1) begin
        cnt_d = '0;
        if (rx_in != ^sh_q) begin
          st_d  = RX_DEAD;
          err_d = 1'b1;
        end else begin
          st_d = RX_STOP;
        end
      end
      RX_STOP: if (cnt_q == FULL_M1) begin
        cnt_d = '0;
        vld_d = 1'b1;
        st_d  = RX_IDLE;
      end
      default: cnt_d = '0;
    endcase
    if (!chip_sel) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
      vld_d = 1'b0;
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign rx_data  = sh_q;
  assign rx_valid = vld_q;
  assign par_err  = err_q;

  // R5: the error stays latched while chip select is high
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && chip_sel) |=> par_err);
  // R5: a dead link never delivers a byte
  p_no_byte_when_dead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> !rx_valid);
  // R6: chip select low clears the error
  p_cs_clears_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> !par_err);
endmodule

// File: rtl/serlink_tx.sv
module serlink_tx
  import serlink_pkg::*;
#(
  parameter int BIT_CLKS = 512,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic              par_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              tx_last,
  output logic              tx_ready,
  input  logic              busy_on,
  input  logic              busy_lvl,
  output logic              line_bit,
  output logic              line_oe
);
  localparam int CNT_W = $clog2(BIT_CLKS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(BIT_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_W - 1);

  tx_state_t         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              last_q, last_d;
  logic              hold_q, hold_d;
  logic              take;
  logic              bit_end;

  assign tx_ready = live && (st_q == TX_IDLE);
  assign take     = tx_ready && tx_valid;
  assign bit_end  = (cnt_q == FULL_M1);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + 1'b1;
    idx_d  = idx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    last_d = last_q;
    hold_d = hold_q;
    case (st_q)
      TX_IDLE: begin
        cnt_d = '0;
        if (take) begin
          st_d   = TX_START;
          sh_d   = tx_data;
          par_d  = ^tx_data;
          last_d = tx_last;
          hold_d = 1'b0;
        end
      end
      TX_START: if (bit_end) begin
        cnt_d = '0;
        idx_d = '0;
        st_d  = TX_DATA;
      end
      TX_DATA: if (bit_end) begin
        cnt_d = '0;
        sh_d  = sh_q >> 1;
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_TOP) st_d = par_en ? TX_PAR : TX_STOP;
      end
      TX_PAR: if (bit_end) begin
        cnt_d = '0;
        st_d  = TX_STOP;
      end
      default: if (bit_end) begin
        cnt_d  = '0;
        st_d   = TX_IDLE;
        hold_d = !last_q;
      end
    endcase
    if (!live) begin
      st_d   = TX_IDLE;
      cnt_d  = '0;
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      last_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      last_q <= last_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    line_oe  = 1'b1;
    line_bit = 1'b1;
    case (st_q)
      TX_IDLE: begin
        line_oe  = hold_q || busy_on;
        line_bit = hold_q ? 1'b1 : busy_lvl;
      end
      TX_START: line_bit = 1'b0;
      TX_DATA:  line_bit = sh_q[0];
      TX_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
    if (!live) line_oe = 1'b0;
  end

  // R1: an accepted byte begins with a driven start bit
  p_accept_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && live) |=> (!live || (line_oe && !line_bit)));
  // R10: ready falls right after a byte is taken
  p_accept_drops_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !tx_ready);
endmodule

// File: rtl/serlink_front.sv
module serlink_front #(
  parameter int BIT_CLKS = 512,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              par_en,
  input  logic              rx_in,
  output logic              tx_out,
  output logic              tx_oe,
  output logic              err_pull,
  output logic              par_err_flag,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              tx_last,
  output logic              tx_ready,
  input  logic              busy_on,
  input  logic              busy_lvl
);
  logic par_err;
  logic live;

  assign live = chip_sel && !par_err;

  serlink_rx #(.BIT_CLKS(BIT_CLKS), .DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_sel (chip_sel),
    .par_en   (par_en),
    .rx_in    (rx_in),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .par_err  (par_err)
  );

  serlink_tx #(.BIT_CLKS(BIT_CLKS), .DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (live),
    .par_en   (par_en),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .tx_ready (tx_ready),
    .busy_on  (busy_on),
    .busy_lvl (busy_lvl),
    .line_bit (tx_out),
    .line_oe  (tx_oe)
  );

  assign err_pull     = par_err;
  assign par_err_flag = par_err;

  // R6: chip select low releases the output line and stops accepting bytes
  p_cs_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |-> (!tx_oe && !tx_ready));
  // R5: while the error output pulls low, the transmitter takes nothing
  p_err_blocks_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pull |-> !tx_ready);
endmodule

// File: tb/tb_serlink_front.sv
module tb_serlink_front;
  localparam int DIV  = 16;
  localparam int HALF = DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_sel = 1'b0;
  logic       par_en = 1'b0;
  logic       rx_in = 1'b1;
  logic       tx_out, tx_oe, err_pull, par_err_flag, rx_valid, tx_ready;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_last = 1'b0;
  logic       busy_on = 1'b0;
  logic       busy_lvl = 1'b0;

  int total = 0;
  int bad = 0;
  int got_cnt = 0;
  logic [7:0] got_q [0:31];
  logic done = 1'b0;

  always #2 clk = ~clk;

  serlink_front #(.BIT_CLKS(DIV), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .par_en(par_en),
    .rx_in(rx_in), .tx_out(tx_out), .tx_oe(tx_oe), .err_pull(err_pull),
    .par_err_flag(par_err_flag), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_ready(tx_ready), .busy_on(busy_on), .busy_lvl(busy_lvl)
  );

  always @(posedge clk) if (rx_valid) begin
    got_q[got_cnt[4:0]] <= rx_data;
    got_cnt <= got_cnt + 1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input logic with_par, input logic pbit);
    rx_in = 1'b0; idle(DIV);
    for (int i = 0; i < 8; i++) begin rx_in = d[i]; idle(DIV); end
    if (with_par) begin rx_in = pbit; idle(DIV); end
    rx_in = 1'b1; idle(DIV);
    idle(4);
  endtask

  task automatic offer(input logic [7:0] d, input logic last);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_last = last; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic grab(input logic with_par, output logic [7:0] d, output logic p,
                      output logic frame_ok);
    int guard = 0;
    while (!(tx_oe && !tx_out) && guard < 4 * DIV) begin @(negedge clk); guard++; end
    idle(HALF);
    frame_ok = tx_oe && !tx_out;
    for (int i = 0; i < 8; i++) begin idle(DIV); d[i] = tx_out; end
    p = 1'b0;
    if (with_par) begin idle(DIV); p = tx_out; end
    idle(DIV);
    frame_ok = frame_ok && tx_oe && tx_out;
  endtask

  task automatic t_reset;
    chk(tx_oe == 1'b0, "R7 reset oe", tx_oe, 0);
    chk(err_pull == 1'b0 && par_err_flag == 1'b0, "R5 reset err", err_pull, 0);
    chk(rx_valid == 1'b0, "R1 reset valid", rx_valid, 0);
    chk(tx_ready == 1'b1, "R10 reset ready", tx_ready, 1);
  endtask

  task automatic t_rx_plain;
    int base = got_cnt;
    par_en = 1'b0;
    send_char(8'hA5, 1'b0, 1'b0);
    chk(got_cnt == base + 1, "R1 rx count", got_cnt - base, 1);
    chk(got_q[base[4:0]] == 8'hA5, "R1 R3 rx byte", got_q[base[4:0]], 8'hA5);
  endtask

  task automatic t_rx_parity;
    int base = got_cnt;
    par_en = 1'b1;
    send_char(8'h3C, 1'b1, 1'b0);
    send_char(8'h01, 1'b1, 1'b1);
    chk(got_cnt == base + 2, "R2 rx parity count", got_cnt - base, 2);
    chk(got_q[base[4:0]] == 8'h3C, "R2 rx parity byte0", got_q[base[4:0]], 8'h3C);
    chk(got_q[5'(base + 1)] == 8'h01, "R2 rx parity byte1", got_q[5'(base + 1)], 8'h01);
    chk(err_pull == 1'b0, "R2 no error on good parity", err_pull, 0);
    par_en = 1'b0;
  endtask

  task automatic t_idle_ones;
    int base = got_cnt;
    send_char(8'h11, 1'b0, 1'b0);
    idle(37);
    send_char(8'hEE, 1'b0, 1'b0);
    chk(got_cnt == base + 2, "R4 idle ones count", got_cnt - base, 2);
    chk(got_q[5'(base + 1)] == 8'hEE, "R4 byte after idle", got_q[5'(base + 1)], 8'hEE);
  endtask

  task automatic t_glitch;
    int base = got_cnt;
    rx_in = 1'b0; idle(3); rx_in = 1'b1;
    idle(3 * DIV);
    chk(got_cnt == base, "R4 glitch dropped", got_cnt - base, 0);
    send_char(8'h42, 1'b0, 1'b0);
    chk(got_cnt == base + 1 && got_q[base[4:0]] == 8'h42, "R4 byte after glitch",
        got_q[base[4:0]], 8'h42);
  endtask

  task automatic t_parity_error;
    int base = got_cnt;
    par_en = 1'b1;
    send_char(8'h01, 1'b1, 1'b0);
    chk(got_cnt == base, "R5 bad byte not delivered", got_cnt - base, 0);
    chk(err_pull == 1'b1, "R5 err output", err_pull, 1);
    chk(par_err_flag == 1'b1, "R5 sticky flag", par_err_flag, 1);
    chk(tx_ready == 1'b0, "R5 tx refused", tx_ready, 0);
    send_char(8'h81, 1'b1, 1'b0);
    chk(got_cnt == base, "R5 dead link ignores rx", got_cnt - base, 0);
    chk(err_pull == 1'b1 && par_err_flag == 1'b1, "R5 error held", err_pull, 1);
    @(negedge clk); chip_sel = 1'b0;
    @(negedge clk);
    chk(err_pull == 1'b0 && par_err_flag == 1'b0, "R6 cs clears error", err_pull, 0);
    chk(tx_ready == 1'b0, "R6 no ready while deselected", tx_ready, 0);
    chip_sel = 1'b1; idle(2);
    send_char(8'h81, 1'b1, 1'b0);
    chk(got_cnt == base + 1 && got_q[base[4:0]] == 8'h81, "R6 link recovered",
        got_q[base[4:0]], 8'h81);
    par_en = 1'b0;
  endtask

  task automatic t_tx_plain;
    logic [7:0] d; logic p; logic ok;
    par_en = 1'b0;
    offer(8'h5A, 1'b1);
    grab(1'b0, d, p, ok);
    chk(ok, "R1 tx frame", ok, 1);
    chk(d == 8'h5A, "R1 tx byte lsb first", d, 8'h5A);
    idle(DIV);
    chk(tx_oe == 1'b0, "R7 released after last", tx_oe, 0);
  endtask

  task automatic t_tx_parity;
    logic [7:0] d; logic p; logic ok;
    par_en = 1'b1;
    offer(8'h07, 1'b1);
    grab(1'b1, d, p, ok);
    chk(ok && d == 8'h07, "R2 tx byte with parity", d, 8'h07);
    chk(p == 1'b1, "R2 tx even parity bit", p, 1);
    idle(DIV);
    par_en = 1'b0;
  endtask

  task automatic t_tx_multi;
    logic [7:0] d; logic p; logic ok;
    offer(8'hC3, 1'b0);
    grab(1'b0, d, p, ok);
    chk(ok && d == 8'hC3, "R1 multi byte0", d, 8'hC3);
    idle(DIV);
    chk(tx_oe == 1'b1 && tx_out == 1'b1, "R8 mark held between bytes", {tx_oe, tx_out}, 3);
    offer(8'h96, 1'b1);
    grab(1'b0, d, p, ok);
    chk(ok && d == 8'h96, "R8 multi byte1", d, 8'h96);
    idle(DIV);
    chk(tx_oe == 1'b0, "R7 released after response", tx_oe, 0);
  endtask

  task automatic t_cs_abort;
    offer(8'hFF, 1'b1);
    idle(3 * DIV);
    chk(tx_oe == 1'b1, "R7 driving mid-byte", tx_oe, 1);
    chip_sel = 1'b0;
    @(negedge clk);
    chk(tx_oe == 1'b0, "R6 cs releases line", tx_oe, 0);
    chip_sel = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b1 && tx_oe == 1'b0, "R6 transfer abandoned", tx_ready, 1);
  endtask

  task automatic t_busy;
    busy_on = 1'b1; busy_lvl = 1'b0;
    @(negedge clk);
    chk(tx_oe == 1'b1 && tx_out == 1'b0, "R9 busy low", {tx_oe, tx_out}, 2);
    busy_lvl = 1'b1;
    @(negedge clk);
    chk(tx_oe == 1'b1 && tx_out == 1'b1, "R9 ready high", {tx_oe, tx_out}, 3);
    busy_on = 1'b0;
    @(negedge clk);
    chk(tx_oe == 1'b0, "R7 released after busy", tx_oe, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    chip_sel = 1'b1;
    idle(2);
    t_reset;
    t_rx_plain;
    t_rx_parity;
    t_idle_ones;
    t_glitch;
    t_tx_plain;
    t_tx_parity;
    t_tx_multi;
    t_cs_abort;
    t_busy;
    t_parity_error;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule